// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Generation

This block serialises characters onto a single transmit line. A character is framed with a low start bit, 8 or 9 data bits sent least significant bit first, and a high stop bit. The line moves on by one bit each time the `baud_tick` strobe is high on a clock edge. A single holding register sits in front of the shift register. Two status flags tell the host whether the holding register can take another character (`tdre`) and whether all traffic has drained (`tc`). An interrupt line combines the two flags, each under its own enable.

The transmitter can also send break characters, which are long runs of low bits. The run is longer when the frame is wider, and longer again when the long-break option is selected. A brief pulse on the break control sends exactly one break. Holding the control high sends complete breaks one after another. Turning the transmitter on sends one frame-length run of high bits (the idle preamble) before anything else. Turning it off lets the item already in progress finish and then leaves the line released and high.

Top module: `async_tx_brk`

## Requirements
- R1: After reset, `txd` is 1, `tx_drive` is 0, `tdre` is 1 and `tc` is 1.
- R2: A data frame is a 0 start bit, then `wr_data[7:0]` least significant bit first, then `wr_data[8]` only when `nine_bit` is 1, then a 1 stop bit. The frame is 10 or 11 bit periods long.
- R3: A break is a run of 0s followed by one 1 bit. The run is 10 bits when `nine_bit`=0 and 11 when `nine_bit`=1. Setting `long_brk` makes it 13 or 14.
- R4: A rising edge of `brk_req` that drops before its break starts still sends exactly one complete break. While `brk_req` stays 1, complete breaks follow back to back.
- R5: A rising edge of `tx_en` queues an idle preamble of 1s that is one frame long (10 or 11 bits).
- R6: A write (`wr_strobe`) clears `tdre`. `tdre` sets again on the bit tick that moves the data into the shift register.
- R7: `tc` is 1 only when the shifter is idle, the holding register is empty and no preamble or break is pending. Queuing any of these clears it.
- R8: `irq` is 1 exactly when (`tdre` and `empty_ie`) or (`tc` and `done_ie`).
- R9: With `tx_en` low, no new item starts. An item already in progress completes. After that, `tx_drive` is 0 and `txd` is 1, and a held character waits until the transmitter is enabled again.
- R10: `txd` changes only on a clock edge where `baud_tick` is 1, and the bits of one item follow each other with no gap.
- R11: When several items are ready, the preamble goes first, then a break, then data.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle strobe marking each bit boundary |
| tx_en | input | 1 | Transmitter enable level |
| nine_bit | input | 1 | 1 selects 9 data bits per frame |
| long_brk | input | 1 | 1 lengthens each break by 3 bits |
| brk_req | input | 1 | Break control level |
| wr_strobe | input | 1 | Writes `wr_data` into the holding register |
| wr_data | input | 9 | Character to send; bit 8 is used only in 9-bit mode |
| empty_ie | input | 1 | Interrupt enable for `tdre` |
| done_ie | input | 1 | Interrupt enable for `tc` |
| txd | output | 1 | Serial output line |
| tx_drive | output | 1 | High while the transmitter owns the line |
| tdre | output | 1 | Holding register empty |
| tc | output | 1 | All transmission complete |
| irq | output | 1 | Gated interrupt request |

## Verification
Some rules are checked on every cycle. The line moves only on bit ticks. A cleared flag goes with a write. A rising empty flag goes with a transfer into the shifter. A set complete flag implies an idle shifter. A disabled idle transmitter never starts an item. Other behaviour shows only in the bench's bit-by-bit comparison against a queue of expected bits:
- the exact framing in both widths;
- the four break lengths and the trailing mark;
- one break from a short pulse versus repeated breaks from a held control;
- the preamble on enable;
- the order when preamble, break and data compete.

// File: rtl/stx_pkg.sv
package stx_pkg;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_PRE  = 2'd1,
      SRC_BRK  = 2'd2,
      SRC_DATA = 2'd3
   } stx_src_e;

endpackage

// File: rtl/stx_shifter.sv
module stx_shifter #(
   parameter int SR_W  = 15,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             baud_tick,
   input  logic             load,
   input  logic [SR_W-1:0]  load_word,
   input  logic [CNT_W-1:0] load_len,
   output logic             txd,
   output logic             busy,
   output logic             slot_free
);

   logic [SR_W-1:0]  sr;
   logic [CNT_W-1:0] left;
   logic             on_last;

   assign on_last   = busy && (left == CNT_W'(1));
   assign slot_free = baud_tick && (!busy || on_last);
   assign txd       = sr[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '1;
         left <= '0;
         busy <= 1'b0;
      end else if (load) begin
         sr   <= load_word;
         left <= load_len;
         busy <= 1'b1;
      end else if (baud_tick && busy) begin
         if (on_last) begin
            sr   <= '1;
            left <= '0;
            busy <= 1'b0;
         end else begin
            sr   <= {1'b1, sr[SR_W-1:1]};
            left <= left - CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/stx_arbiter.sv
module stx_arbiter
   import stx_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int LONG_ADD  = 3,
   parameter int SR_W      = 15,
   parameter int CNT_W     = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tx_en,
   input  logic               brk_req,
   input  logic               nine_bit,
   input  logic               long_brk,
   input  logic               slot_free,
   input  logic               tdr_full,
   input  logic [DATA_BITS:0] tdr_word,
   output logic               load,
   output stx_src_e           load_src,
   output logic [SR_W-1:0]    load_word,
   output logic [CNT_W-1:0]   load_len,
   output logic               pre_pend,
   output logic               brk_pend
);

   logic             en_q, brk_q;
   logic             en_rise, brk_rise, pre_eff;
   logic [CNT_W-1:0] frame_len, brk_zeros;
   logic [SR_W-1:0]  dword;

   assign en_rise  = tx_en && !en_q;
   assign brk_rise = brk_req && !brk_q;
   assign pre_eff  = pre_pend || en_rise;

   assign frame_len = CNT_W'(DATA_BITS + 2) + CNT_W'(nine_bit);

   generate
      if (LONG_ADD == 0) begin : g_no_long
         assign brk_zeros = frame_len;
      end else begin : g_long
         assign brk_zeros = frame_len + (long_brk ? CNT_W'(LONG_ADD) : CNT_W'(0));
      end
   endgenerate

   // preamble beats break beats data
   always_comb begin
      load_src = SRC_NONE;
      if (slot_free && tx_en) begin
         if (pre_eff)                  load_src = SRC_PRE;
         else if (brk_pend || brk_req) load_src = SRC_BRK;
         else if (tdr_full)            load_src = SRC_DATA;
      end
   end

   assign load = (load_src != SRC_NONE);

   always_comb begin
      dword              = '1;
      dword[0]           = 1'b0;
      dword[DATA_BITS:1] = tdr_word[DATA_BITS-1:0];
      if (nine_bit) dword[DATA_BITS+1] = tdr_word[DATA_BITS];
   end

   always_comb begin
      load_word = '1;
      load_len  = frame_len;
      case (load_src)
         SRC_BRK: begin
            load_word = {SR_W{1'b1}} << brk_zeros;
            load_len  = brk_zeros + CNT_W'(1);
         end
         SRC_DATA: load_word = dword;
         default:  load_word = '1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         brk_q    <= 1'b0;
         pre_pend <= 1'b0;
         brk_pend <= 1'b0;
      end else begin
         en_q  <= tx_en;
         brk_q <= brk_req;
         if (!tx_en || load_src == SRC_PRE) pre_pend <= 1'b0;
         else if (en_rise)                   pre_pend <= 1'b1;
         if (!tx_en || load_src == SRC_BRK) brk_pend <= 1'b0;
         else if (brk_rise)                  brk_pend <= 1'b1;
      end
   end

endmodule

// File: rtl/stx_holdreg.sv
module stx_holdreg #(
   parameter int DATA_BITS = 8,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_strobe,
   input  logic [DATA_BITS:0] wr_data,
   input  logic               take,
   input  logic               busy,
   input  logic               pre_pend,
   input  logic               brk_pend,
   input  logic               brk_live,
   input  logic               empty_ie,
   input  logic               done_ie,
   output logic               tdr_full,
   output logic [DATA_BITS:0] tdr_word,
   output logic               tdre,
   output logic               tc,
   output logic               irq
);

   logic irq_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdr_full <= 1'b0;
         tdr_word <= '0;
      end else if (wr_strobe) begin
         tdr_full <= 1'b1;
         tdr_word <= wr_data;
      end else if (take) begin
         tdr_full <= 1'b0;
      end
   end

   assign tdre  = !tdr_full;
   assign tc    = !busy && !tdr_full && !pre_pend && !brk_pend && !brk_live;
   assign irq_d = (tdre && empty_ie) || (tc && done_ie);

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_d;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_d;
      end
   endgenerate

   a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> !tdre);

   a_r6_rise_on_take: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tdre) |-> $past(take));

endmodule

// File: rtl/async_tx_brk.sv
module async_tx_brk
   import stx_pkg::*;
#(
   parameter int DATA_BITS = 8,
   parameter int LONG_ADD  = 3,
   parameter bit IRQ_REG   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               baud_tick,
   input  logic               tx_en,
   input  logic               nine_bit,
   input  logic               long_brk,
   input  logic               brk_req,
   input  logic               wr_strobe,
   input  logic [DATA_BITS:0] wr_data,
   input  logic               empty_ie,
   input  logic               done_ie,
   output logic               txd,
   output logic               tx_drive,
   output logic               tdre,
   output logic               tc,
   output logic               irq
);

   localparam int SR_W  = DATA_BITS + LONG_ADD + 4;
   localparam int CNT_W = $clog2(SR_W + 1);

   generate
      if (DATA_BITS < 5 || DATA_BITS > 12) begin : g_bad_data_bits
         $error("async_tx_brk: DATA_BITS must lie in 5..12");
      end
      if (LONG_ADD < 0 || LONG_ADD > 8) begin : g_bad_long_add
         $error("async_tx_brk: LONG_ADD must lie in 0..8");
      end
   endgenerate

   logic               load, busy, slot_free;
   logic               pre_pend, brk_pend, tdr_full;
   logic [DATA_BITS:0] tdr_word;
   logic [SR_W-1:0]    load_word;
   logic [CNT_W-1:0]   load_len;
   stx_src_e           load_src;

   stx_arbiter #(
      .DATA_BITS(DATA_BITS), .LONG_ADD(LONG_ADD), .SR_W(SR_W), .CNT_W(CNT_W)
   ) u_arb (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_req(brk_req),
      .nine_bit(nine_bit), .long_brk(long_brk), .slot_free(slot_free),
      .tdr_full(tdr_full), .tdr_word(tdr_word), .load(load),
      .load_src(load_src), .load_word(load_word), .load_len(load_len),
      .pre_pend(pre_pend), .brk_pend(brk_pend)
   );

   stx_shifter #(.SR_W(SR_W), .CNT_W(CNT_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .load(load),
      .load_word(load_word), .load_len(load_len), .txd(txd),
      .busy(busy), .slot_free(slot_free)
   );

   stx_holdreg #(.DATA_BITS(DATA_BITS), .IRQ_REG(IRQ_REG)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_data(wr_data),
      .take(load_src == SRC_DATA), .busy(busy), .pre_pend(pre_pend),
      .brk_pend(brk_pend), .brk_live(tx_en && brk_req),
      .empty_ie(empty_ie), .done_ie(done_ie), .tdr_full(tdr_full),
      .tdr_word(tdr_word), .tdre(tdre), .tc(tc), .irq(irq)
   );

   assign tx_drive = tx_en || busy;

   a_r10_txd_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !baud_tick |=> $stable(txd));

   a_r9_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !busy) |=> !busy);

   a_r7_tc_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> (!busy && tdre && txd));

endmodule

// File: tb/test_async_tx_brk.sv
`timescale 1ns/1ps
module test_async_tx_brk;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0, tx_en = 1'b0, nine_bit = 1'b0, long_brk = 1'b0;
   logic       brk_req = 1'b0, wr_strobe = 1'b0, empty_ie = 1'b0, done_ie = 1'b0;
   logic [8:0] wr_data = '0;
   logic       txd, tx_drive, tdre, tc, irq;

   int    n_chk = 0, n_err = 0;
   string cur_req = "R2";
   bit    exp_q[$];
   bit    tick_seen = 1'b0;

   always #2 clk = ~clk;

   async_tx_brk i_async_tx_brk (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
      .nine_bit(nine_bit), .long_brk(long_brk), .brk_req(brk_req),
      .wr_strobe(wr_strobe), .wr_data(wr_data), .empty_ie(empty_ie),
      .done_ie(done_ie), .txd(txd), .tx_drive(tx_drive), .tdre(tdre),
      .tc(tc), .irq(irq)
   );

   // monitor: after every bit tick the line must show the next queued bit
   always @(posedge clk) tick_seen <= baud_tick;

   always @(negedge clk) begin
      bit e;
      if (rst_n && tick_seen) begin
         e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b1;
         n_chk++;
         if (txd !== e) begin
            n_err++;
            $display("FAIL %s txd actual=%b expected=%b", cur_req, txd, e);
         end
      end
   end

   task automatic chk(string req, logic act, logic exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic tick(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) baud_tick = 1'b1;
         @(negedge clk) baud_tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic drain();
      while (exp_q.size() > 0) tick(1);
      tick(2);
   endtask

   task automatic wr(logic [8:0] d);
      @(negedge clk);
      wr_data   = d;
      wr_strobe = 1'b1;
      @(negedge clk);
      wr_strobe = 1'b0;
   endtask

   task automatic push_ones(int n);
      for (int i = 0; i < n; i++) exp_q.push_back(1'b1);
   endtask

   task automatic push_frame(logic [8:0] d, bit nine);
      exp_q.push_back(1'b0);
      for (int i = 0; i < 8; i++) exp_q.push_back(d[i]);
      if (nine) exp_q.push_back(d[8]);
      exp_q.push_back(1'b1);
   endtask

   task automatic push_break(bit nine, bit lng);
      int z;
      z = 10 + int'(nine) + (lng ? 3 : 0);
      for (int i = 0; i < z; i++) exp_q.push_back(1'b0);
      exp_q.push_back(1'b1);
   endtask

   task automatic pulse_break();
      @(negedge clk) brk_req = 1'b1;
      @(negedge clk) brk_req = 1'b0;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired before the run completed");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", txd, 1'b1, "txd");
      chk("R1", tx_drive, 1'b0, "tx_drive");
      chk("R1", tdre, 1'b1, "tdre");
      chk("R1", tc, 1'b1, "tc");

      // R8 gating with both flags set
      empty_ie = 1'b1; @(negedge clk);
      chk("R8", irq, 1'b1, "irq empty_ie only");
      empty_ie = 1'b0; done_ie = 1'b1; @(negedge clk);
      chk("R8", irq, 1'b1, "irq done_ie only");
      done_ie = 1'b0; @(negedge clk);
      chk("R8", irq, 1'b0, "irq no enables");

      // write while disabled: nothing leaves, flags drop
      cur_req = "R9";
      wr(9'h0A5);
      chk("R6", tdre, 1'b0, "tdre after write");
      chk("R7", tc, 1'b0, "tc with held data");
      empty_ie = 1'b1; @(negedge clk);
      chk("R8", irq, 1'b0, "irq tdre clear");
      empty_ie = 1'b0; done_ie = 1'b1; @(negedge clk);
      chk("R8", irq, 1'b0, "irq tc clear");
      done_ie = 1'b0;
      tick(3);
      chk("R9", tx_drive, 1'b0, "tx_drive while disabled");

      // enable: preamble first, then the held character (R5, R11)
      cur_req = "R5";
      @(negedge clk) tx_en = 1'b1;
      push_ones(10);
      push_frame(9'h0A5, 1'b0);
      tick(10);
      chk("R11", tdre, 1'b0, "tdre during preamble");
      chk("R7", tc, 1'b0, "tc during preamble");
      tick(1);
      chk("R6", tdre, 1'b1, "tdre after transfer");
      cur_req = "R2";
      drain();
      chk("R7", tc, 1'b1, "tc after drain");

      // back to back characters
      cur_req = "R10";
      wr(9'h03C); push_frame(9'h03C, 1'b0);
      tick(1);
      chk("R6", tdre, 1'b1, "tdre after first load");
      wr(9'h0C3); push_frame(9'h0C3, 1'b0);
      chk("R6", tdre, 1'b0, "tdre with second held");
      drain();

      // one short break pulse gives exactly one break
      cur_req = "R4";
      pulse_break(); push_break(1'b0, 1'b0);
      tick(3);
      chk("R7", tc, 1'b0, "tc during break");
      cur_req = "R3";
      drain();

      // held break, long option: two complete breaks
      cur_req = "R4";
      long_brk = 1'b1;
      @(negedge clk) brk_req = 1'b1;
      push_break(1'b0, 1'b1); push_break(1'b0, 1'b1);
      while (exp_q.size() > 13) tick(1);
      brk_req = 1'b0;
      drain();
      long_brk = 1'b0;
      chk("R4", tc, 1'b1, "tc after held breaks");

      // 9-bit mode: frame and both break lengths
      cur_req = "R2";
      nine_bit = 1'b1;
      wr(9'h1A6); push_frame(9'h1A6, 1'b1);
      drain();
      cur_req = "R3";
      pulse_break(); push_break(1'b1, 1'b0);
      drain();
      long_brk = 1'b1;
      pulse_break(); push_break(1'b1, 1'b1);
      drain();
      long_brk = 1'b0; nine_bit = 1'b0;

      // break and data queued together: break leaves first
      cur_req = "R11";
      @(negedge clk);
      wr_data = 9'h081; wr_strobe = 1'b1; brk_req = 1'b1;
      @(negedge clk);
      wr_strobe = 1'b0; brk_req = 1'b0;
      push_break(1'b0, 1'b0); push_frame(9'h081, 1'b0);
      tick(1);
      chk("R11", tdre, 1'b0, "tdre while break first");
      drain();

      // disable in mid frame: frame completes, next character waits
      cur_req = "R9";
      wr(9'h055); push_frame(9'h055, 1'b0);
      tick(4);
      @(negedge clk) tx_en = 1'b0;
      wr(9'h00F);
      chk("R9", tx_drive, 1'b1, "tx_drive finishing frame");
      drain();
      tick(2);
      chk("R9", tx_drive, 1'b0, "tx_drive after finish");
      chk("R9", txd, 1'b1, "txd released");
      chk("R9", tdre, 1'b0, "held data kept");
      cur_req = "R5";
      @(negedge clk) tx_en = 1'b1;
      push_ones(10); push_frame(9'h00F, 1'b0);
      drain();
      chk("R6", tdre, 1'b1, "tdre after resend");
      chk("R7", tc, 1'b1, "tc final");
      n_chk++;
      if (exp_q.size() != 0) begin
         n_err++;
         $display("FAIL R10 leftover bits actual=%0d expected=0", exp_q.size());
      end
      finish_run();
   end

endmodule